// File: doc/BRIEF.md
# Ordered-Port Bypass Register

This block is one storage register shared by several read/write port pairs. The port pairs follow a fixed order. When several pairs use the register in the same clock cycle, the result is the same as if they had run one after another in port order. Port pair k has a combinational read output, a write enable and write data. A read on port k returns the stored value after every enabled write on a lower-numbered port in the same cycle has been applied. At the clock edge the register keeps the result of the whole chain of writes.

A typical use is a counter or a status word that several agents update in the same cycle. Each agent is given one port pair in the order it should appear to act. The port count, the data width and the reset value are parameters.

The ports are plain control and data pins with no valid/ready handshake. A write enable is taken as a request that always succeeds in its own cycle, so the block never applies back-pressure and never stalls a port. Port lanes are packed into flat vectors: lane k occupies bits [k*DATA_W +: DATA_W] of `wr_data` and `rd_data`, and bit k of `wr_en`.

Top module: `multi_port_ehr`

## Requirements
- R1: When `rst` is high at a clock edge, the stored value becomes RESET_VAL. This happens whatever the write enables and write data are.
- R2: Read lane 0 always returns the stored register value. No write input in the current cycle affects it.
- R3: Read lane k (k >= 1) returns the write data of the highest-numbered enabled write lane j with j < k. If no such lane is enabled, it returns the stored value.
- R4: After a clock edge without reset, the stored value equals the write data of the highest-numbered enabled lane. If no lane is enabled, the stored value is unchanged.
- R5: The enable and data of write lane k and of every higher lane have no effect on read lanes 0 to k in the same cycle.
- R6: The stored value changes only at a clock edge. Input changes between edges do not alter read lane 0.
- R7: With no write enable asserted, every read lane returns the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_PORTS | Write enable, bit k for lane k |
| wr_data | input | NUM_PORTS*DATA_W | Write data, lane k at bits [k*DATA_W +: DATA_W] |
| rd_data | output | NUM_PORTS*DATA_W | Read data, lane k at bits [k*DATA_W +: DATA_W] |

## Verification
A wrong stored value appears on read lane 0 one clock edge after the write that caused it. Lane 0 has no bypass, so the fault then shows on every lane that has no lower enabled writer. A fault in the bypass chain (wrong priority, or a lane seeing its own or a higher writer) appears on the affected read lanes in the same cycle, with no edge needed. The bench therefore compares all read lanes between edges, and lane 0 again just after each edge, for every enable pattern.

// File: rtl/ehr_pkg.sv
package ehr_pkg;
  localparam int unsigned EHR_PORTS_DEF = 2;
  localparam int unsigned EHR_WIDTH_DEF = 32;
endpackage

// File: rtl/ehr_bypass_stage.sv
// One link of the ordered write chain: the lane's data wins when it is enabled.
module ehr_bypass_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] prev,
  output logic [DATA_W-1:0] nxt
);
  always_comb begin
    nxt = en ? wdata : prev;
  end
endmodule

// File: rtl/ehr_state_reg.sv
module ehr_state_reg #(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/multi_port_ehr.sv
module multi_port_ehr
  import ehr_pkg::*;
#(
  parameter int unsigned       NUM_PORTS = EHR_PORTS_DEF,
  parameter int unsigned       DATA_W    = EHR_WIDTH_DEF,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        wr_en,
  input  logic [NUM_PORTS*DATA_W-1:0] wr_data,
  output logic [NUM_PORTS*DATA_W-1:0] rd_data
);
  localparam int unsigned TOTAL_W = NUM_PORTS * DATA_W;

  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] chain [NUM_PORTS+1];

  initial begin
    if (NUM_PORTS < 1) $error("NUM_PORTS must be at least 1");
  end

  assign chain[0] = stored;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_lane
    ehr_bypass_stage #(.DATA_W(DATA_W)) stage_i (
      .en    (wr_en[k]),
      .wdata (wr_data[k*DATA_W +: DATA_W]),
      .prev  (chain[k]),
      .nxt   (chain[k+1])
    );
    assign rd_data[k*DATA_W +: DATA_W] = chain[k];

    if (k > 0) begin : g_chk
      // R3: an enabled writer directly below lane k is what lane k reads
      assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en[k-1] |-> rd_data[k*DATA_W +: DATA_W] == wr_data[(k-1)*DATA_W +: DATA_W]);
    end
  end

  ehr_state_reg #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) state_i (
    .clk (clk),
    .rst (rst),
    .d   (chain[NUM_PORTS]),
    .q   (stored)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> rd_data[DATA_W-1:0] == RESET_VAL);

  assert_last_wins_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en[NUM_PORTS-1] |=> rd_data[DATA_W-1:0] == $past(wr_data[TOTAL_W-1 -: DATA_W]));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> $stable(rd_data[DATA_W-1:0]));

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |-> rd_data == {NUM_PORTS{rd_data[DATA_W-1:0]}});
endmodule

// File: tb/multi_port_ehr_tb_top.sv
module multi_port_ehr_tb_top;
  localparam int unsigned NP = 3;
  localparam int unsigned W  = 4;
  localparam logic [W-1:0] RV = 4'hA;

  logic            clk = 1'b0;
  logic            rst;
  logic [NP-1:0]   wr_en;
  logic [NP*W-1:0] wr_data;
  logic [NP*W-1:0] rd_data;
  logic [W-1:0]    model;
  int              n_chk = 0;
  int              n_fail = 0;

  always #5 clk = ~clk;

  multi_port_ehr #(.NUM_PORTS(NP), .DATA_W(W), .RESET_VAL(RV)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_rd(int k, logic [NP-1:0] en,
                                          logic [NP*W-1:0] d, logic [W-1:0] st);
    logic [W-1:0] cur = st;
    for (int j = 0; j < k; j++) if (en[j]) cur = d[j*W +: W];
    return cur;
  endfunction

  task automatic step(logic [NP-1:0] en, int seed);
    logic [NP*W-1:0] d;
    @(negedge clk);
    for (int i = 0; i < NP; i++) d[i*W +: W] = W'((seed * 7 + i * 5 + int'(en) * 3) & 15);
    wr_en = en; wr_data = d;
    #1;
    chk("R6 lane0 unchanged between edges", rd_data[W-1:0], model);
    for (int k = 0; k < NP; k++)
      chk(k == 0 ? "R2" : (en == 0 ? "R7" : "R3"), rd_data[k*W +: W], exp_rd(k, en, d, model));
    // R5: top lane's write inputs must not reach any read lane
    wr_en[NP-1] = ~en[NP-1];
    wr_data[(NP-1)*W +: W] = ~d[(NP-1)*W +: W];
    #1;
    for (int k = 0; k < NP; k++)
      chk("R5", rd_data[k*W +: W], exp_rd(k, en, d, model));
    wr_en = en; wr_data = d;
    @(posedge clk);
    model = exp_rd(NP, en, d, model);
    #1;
    chk("R4", rd_data[W-1:0], model);
  endtask

  initial begin
    rst = 1'b1; wr_en = '1; wr_data = '1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset value", rd_data[W-1:0], RV);
    rst = 1'b0; wr_en = '0;
    model = RV;
    #1;
    for (int k = 0; k < NP; k++) chk("R7 after reset", rd_data[k*W +: W], RV);
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < (1 << NP); e++) step(NP'(e), s);
    @(negedge clk);
    rst = 1'b1; wr_en = '1; wr_data = 12'h5C3;
    @(posedge clk); #1;
    chk("R1 reset overrides writes", rd_data[W-1:0], RV);
    @(negedge clk);
    rst = 1'b0; wr_en = '0;
    #1;
    for (int k = 0; k < NP; k++) chk("R7 idle after reset", rd_data[k*W +: W], RV);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule